// File: doc/BRIEF.md
# Pointer-List Event Readout Sequencer

This block is a bus master that gathers an event from several scattered sources. Software loads two pointer lists through a small slave window in short (A16) I/O space. The first list holds, for each source, the short address of a 16-bit location that gives the number of 32-bit words the source has ready. The second list holds, for each source, the standard (A24) address where that source's data begins. A register gives the number of entries to use.

A `start` pulse runs one pass over the entries, in list order. For each entry the sequencer makes an A16/D16 read through the count pointer. It then makes that many A24/D32 reads at consecutive word addresses from the data pointer, and hands each word downstream over a valid/ready handshake. Writes to the lists and to the entry-count register go into shadow storage. Shadow storage is copied into the working set only when reset is asserted, so a pass never sees a half-edited list.

Top module: `rdseq_top`

## Requirements
- R1: A slave write takes effect only when `slv_wr` is high, `slv_short` is high and `slv_addr[15:13]` equals the `BASE_SEL` parameter (an 8 kB window in short space). Any other write changes nothing.
- R2: Window layout. The entry count is at offset 0x0000. Count pointer i is at offset 0x0100+2i. Data pointer i takes bits 23:16 from `slv_wdata[7:0]` at offset 0x0200+4i, and bits 15:0 at offset 0x0202+4i. Bit 0 of the offset is ignored.
- R3: Written values land in shadow storage. The working entry count and pointer lists are loaded from shadow on every clock edge with `rst` high, and are not altered at any other time.
- R4: An entry-count write larger than `MAX_ENTRIES` is stored as `MAX_ENTRIES`.
- R5: The count for entry i is read with a short cycle (`mst_space`=0, A16/D16) at address {8'h00, count pointer i}. The count is `mst_rdata[15:0]`.
- R6: The data for entry i is read with standard cycles (`mst_space`=1, A24/D32) at data pointer i, +4, +8, …, one read per counted word. Each returned 32-bit word is sent out unchanged.
- R7: Entries are handled in ascending index order. Each entry's count read comes before its data reads.
- R8: An entry whose count is zero issues no data reads, and the pass moves on to the next entry.
- R9: `start` while idle begins a pass. `start` while busy is ignored. With an entry count of zero, a pass makes no bus cycles and sets `done` straight away.
- R10: `busy` is high from the edge after `start` until the last word has left the output stage. `done` then goes high and stays high until the next accepted `start`. `done` and `busy` are never high together.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` holds its value, and no data read is requested.
- R12: A master cycle completes on an edge where `mst_req` and `mst_ack` are both high. After reset, `busy`, `done`, `out_valid` and `mst_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also adopts the shadow configuration |
| slv_wr | input | 1 | Slave write strobe, one word per cycle |
| slv_short | input | 1 | High when the slave cycle is a short (A16) access |
| slv_addr | input | 16 | Slave byte address |
| slv_wdata | input | 16 | Slave write data |
| start | input | 1 | Begin one pass over the entries |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Last pass finished |
| mst_req | output | 1 | Master read request |
| mst_space | output | 1 | 0 = A16/D16 count read, 1 = A24/D32 data read |
| mst_addr | output | 24 | Master read address |
| mst_ack | input | 1 | Read completes this cycle (qualified by `mst_req`) |
| mst_rdata | input | 32 | Read data, valid with `mst_ack` |
| out_valid | output | 1 | Output word available |
| out_data | output | 32 | Output word |
| out_ready | input | 1 | Downstream accepts the word |

## Verification
The assertions assume that `mst_ack` is only taken as meaningful alongside `mst_req`. The master may drop a data request when the output stalls, so the responder must not hold a completion across cycles. The working-set stability check also assumes that every shadow register has been written before the reset that adopts it. The stimulus meets both assumptions. Its responder decides each cycle afresh, from a pseudo-random stall pattern, whether to acknowledge the request currently showing. Each test programs every entry it uses before applying the reset that adopts the list. Back-pressure on `out_ready` comes from the same generator, so stalls on both edges of the block overlap in irregular ways.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

    // Widths fixed by the bus cycles the block makes
    localparam int SLV_W  = 16;   // short-space address and data
    localparam int MST_AW = 24;   // standard-space address
    localparam int DAT_W  = 32;   // data word
    localparam int CNT_W  = 16;   // word count read on D16

    // Offsets inside the 8 kB window
    localparam logic [12:0] OFS_NENT  = 13'h0000;
    localparam logic [4:0]  PAGE_CPTR = 5'h01;
    localparam logic [4:0]  PAGE_DPTR = 5'h02;

    typedef enum logic {
        SP_SHORT = 1'b0,   // A16/D16
        SP_STD   = 1'b1    // A24/D32
    } space_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CNT,
        ST_DAT,
        ST_DRAIN
    } seq_st_e;

    typedef struct packed {
        logic                req;
        space_e              space;
        logic [MST_AW-1:0]   addr;
    } mst_cmd_t;

    function automatic logic [SLV_W-1:0] clamp_to(input logic [SLV_W-1:0] v,
                                                  input logic [SLV_W-1:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/rdseq_cfg.sv
module rdseq_cfg
    import rdseq_pkg::*;
#(
    parameter int          MAX_ENTRIES = 8,     // at most 64: pointer pages hold 64 slots
    parameter logic [2:0]  BASE_SEL    = 3'd5,
    localparam int         NW          = $clog2(MAX_ENTRIES + 1)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr,
    input  logic                              short_am,
    input  logic [SLV_W-1:0]                  addr,
    input  logic [SLV_W-1:0]                  wdata,
    output logic [NW-1:0]                     act_n,
    output logic [MAX_ENTRIES-1:0][SLV_W-1:0] act_cptr,
    output logic [MAX_ENTRIES-1:0][MST_AW-1:0] act_dptr
);

    logic        hit;
    logic [12:0] off;
    logic [NW-1:0] sh_n;
    logic [SLV_W-1:0] n_clamped;

    assign hit       = wr && short_am && (addr[15:13] == BASE_SEL);
    assign off       = addr[12:0];
    assign n_clamped = clamp_to(wdata, SLV_W'(MAX_ENTRIES));

    // Shadow entry count: no reset, it must survive the reset that adopts it
    always_ff @(posedge clk) begin
        if (hit && off[12:1] == OFS_NENT[12:1])
            sh_n <= n_clamped[NW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            act_n <= sh_n;
    end

    for (genvar e = 0; e < MAX_ENTRIES; e++) begin : g_ent
        logic [SLV_W-1:0]  cp_sh, cp_act;
        logic [MST_AW-1:0] dp_sh, dp_act;
        logic              cp_we, dh_we, dl_we;

        assign cp_we = hit && off[12:8] == PAGE_CPTR && off[7:1] == 7'(e);
        assign dh_we = hit && off[12:8] == PAGE_DPTR && off[7:2] == 6'(e) && !off[1];
        assign dl_we = hit && off[12:8] == PAGE_DPTR && off[7:2] == 6'(e) &&  off[1];

        always_ff @(posedge clk) begin
            if (cp_we) cp_sh <= wdata;
            if (dh_we) dp_sh[MST_AW-1:SLV_W] <= wdata[MST_AW-SLV_W-1:0];
            if (dl_we) dp_sh[SLV_W-1:0] <= wdata;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cp_act <= cp_sh;
                dp_act <= dp_sh;
            end
        end

        assign act_cptr[e] = cp_act;
        assign act_dptr[e] = dp_act;
    end

    // R3
    act_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($stable(act_n) && $stable(act_cptr) && $stable(act_dptr)));

endmodule

// File: rtl/rdseq_fetch.sv
module rdseq_fetch
    import rdseq_pkg::*;
#(
    parameter int  MAX_ENTRIES = 8,
    localparam int NW          = $clog2(MAX_ENTRIES + 1),
    localparam int IDX_W       = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               start,
    input  logic [NW-1:0]                      act_n,
    input  logic [MAX_ENTRIES-1:0][SLV_W-1:0]  act_cptr,
    input  logic [MAX_ENTRIES-1:0][MST_AW-1:0] act_dptr,
    input  logic                               out_free,
    input  logic                               out_valid,
    input  logic                               mst_ack,
    input  logic [DAT_W-1:0]                   mst_rdata,
    output mst_cmd_t                           cmd,
    output logic                               ld,
    output logic [DAT_W-1:0]                   ld_data,
    output logic                               busy,
    output logic                               done
);

    seq_st_e           st;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  remain;
    logic [MST_AW-1:0] daddr;
    logic              ack_ok;
    logic              last_ent;

    always_comb begin
        cmd.req   = (st == ST_CNT) || (st == ST_DAT && out_free);
        cmd.space = (st == ST_DAT) ? SP_STD : SP_SHORT;
        cmd.addr  = (st == ST_DAT) ? daddr
                                   : {{(MST_AW-SLV_W){1'b0}}, act_cptr[idx]};
    end

    assign ack_ok   = cmd.req && mst_ack;
    assign last_ent = (NW'(idx) + NW'(1)) == act_n;
    assign ld       = (st == ST_DAT) && ack_ok;
    assign ld_data  = mst_rdata;
    assign busy     = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            idx    <= '0;
            remain <= '0;
            daddr  <= '0;
            done   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        idx <= '0;
                        if (act_n == '0) begin
                            done <= 1'b1;
                        end else begin
                            done <= 1'b0;
                            st   <= ST_CNT;
                        end
                    end
                end
                ST_CNT: begin
                    if (ack_ok) begin
                        if (mst_rdata[CNT_W-1:0] == '0) begin
                            if (last_ent) begin
                                st <= ST_DRAIN;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end else begin
                            remain <= mst_rdata[CNT_W-1:0];
                            daddr  <= act_dptr[idx];
                            st     <= ST_DAT;
                        end
                    end
                end
                ST_DAT: begin
                    if (ack_ok) begin
                        daddr  <= daddr + MST_AW'(4);
                        remain <= remain - 1'b1;
                        if (remain == CNT_W'(1)) begin
                            if (last_ent) begin
                                st <= ST_DRAIN;
                            end else begin
                                idx <= idx + 1'b1;
                                st  <= ST_CNT;
                            end
                        end
                    end
                end
                ST_DRAIN: begin
                    if (!out_valid) begin
                        done <= 1'b1;
                        st   <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R10
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));

    // R7
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CNT || st == ST_DAT) |-> (NW'(idx) < act_n));

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DAT && ack_ok && remain != CNT_W'(1)) |=>
            (st == ST_DAT && cmd.addr == $past(cmd.addr) + MST_AW'(4)));

    // R8
    zero_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CNT && ack_ok && mst_rdata[CNT_W-1:0] == '0) |=> (st != ST_DAT));

endmodule

// File: rtl/rdseq_out.sv
module rdseq_out
    import rdseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [DAT_W-1:0] ld_data,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [DAT_W-1:0] out_data,
    output logic             out_free
);

    assign out_free = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (ld) begin
            out_valid <= 1'b1;
            out_data  <= ld_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R11
    no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
        ld |-> (!out_valid || out_ready));

endmodule

// File: rtl/rdseq_top.sv
module rdseq_top
    import rdseq_pkg::*;
#(
    parameter int         MAX_ENTRIES = 8,
    parameter logic [2:0] BASE_SEL    = 3'd5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        slv_wr,
    input  logic        slv_short,
    input  logic [15:0] slv_addr,
    input  logic [15:0] slv_wdata,
    input  logic        start,
    output logic        busy,
    output logic        done,
    output logic        mst_req,
    output logic        mst_space,
    output logic [23:0] mst_addr,
    input  logic        mst_ack,
    input  logic [31:0] mst_rdata,
    output logic        out_valid,
    output logic [31:0] out_data,
    input  logic        out_ready
);

    localparam int NW = $clog2(MAX_ENTRIES + 1);

    logic [NW-1:0]                      act_n;
    logic [MAX_ENTRIES-1:0][SLV_W-1:0]  act_cptr;
    logic [MAX_ENTRIES-1:0][MST_AW-1:0] act_dptr;
    mst_cmd_t                           cmd;
    logic                               ld;
    logic [DAT_W-1:0]                   ld_data;
    logic                               out_free;

    rdseq_cfg #(.MAX_ENTRIES(MAX_ENTRIES), .BASE_SEL(BASE_SEL)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr       (slv_wr),
        .short_am (slv_short),
        .addr     (slv_addr),
        .wdata    (slv_wdata),
        .act_n    (act_n),
        .act_cptr (act_cptr),
        .act_dptr (act_dptr)
    );

    rdseq_fetch #(.MAX_ENTRIES(MAX_ENTRIES)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .act_n     (act_n),
        .act_cptr  (act_cptr),
        .act_dptr  (act_dptr),
        .out_free  (out_free),
        .out_valid (out_valid),
        .mst_ack   (mst_ack),
        .mst_rdata (mst_rdata),
        .cmd       (cmd),
        .ld        (ld),
        .ld_data   (ld_data),
        .busy      (busy),
        .done      (done)
    );

    rdseq_out u_out (
        .clk       (clk),
        .rst       (rst),
        .ld        (ld),
        .ld_data   (ld_data),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_free  (out_free)
    );

    assign mst_req   = cmd.req;
    assign mst_space = cmd.space;
    assign mst_addr  = cmd.addr;

endmodule

// File: tb/tb_rdseq_top.sv
module tb_rdseq_top;

    localparam int          MAXE = 8;
    localparam logic [15:0] WIN  = 16'hA000;   // BASE_SEL = 5

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slv_wr = 1'b0, slv_short = 1'b0;
    logic [15:0] slv_addr = '0, slv_wdata = '0;
    logic        start = 1'b0;
    logic        busy, done, mst_req, mst_space;
    logic [23:0] mst_addr;
    logic        mst_ack;
    logic [31:0] mst_rdata;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ready;

    rdseq_top #(.MAX_ENTRIES(MAXE), .BASE_SEL(3'd5)) dut (
        .clk(clk), .rst(rst), .slv_wr(slv_wr), .slv_short(slv_short),
        .slv_addr(slv_addr), .slv_wdata(slv_wdata), .start(start),
        .busy(busy), .done(done), .mst_req(mst_req), .mst_space(mst_space),
        .mst_addr(mst_addr), .mst_ack(mst_ack), .mst_rdata(mst_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    always #10 clk = ~clk;   // 50 MHz

    int vectors = 0;
    int miscompares = 0;
    int viol = 0;
    logic bp_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [15:0] cnt_of [logic [15:0]];
    logic [24:0] ops [$];
    logic [31:0] rx  [$];

    // bench model: programmed (shadow) and adopted (working) configuration
    int          p_n, a_n;
    logic [15:0] p_cp [MAXE];
    logic [23:0] p_dp [MAXE];
    logic [15:0] a_cp [MAXE];
    logic [23:0] a_dp [MAXE];

    function automatic logic [31:0] resp(logic sp, logic [23:0] a);
        logic [15:0] c;
        c = cnt_of.exists(a[15:0]) ? cnt_of[a[15:0]] : 16'h0;
        return sp ? {8'hC3, a} : {16'h0, c};
    endfunction

    // bus responder, back-pressure source and output collector
    initial begin
        mst_ack = 1'b0; mst_rdata = '0; out_ready = 1'b1;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = bp_mode ? lfsr[3] : 1'b1;
            #1;
            mst_ack = 1'b0;
            if (!rst && mst_req && (lfsr[5] | lfsr[9])) begin
                mst_ack   = 1'b1;
                mst_rdata = resp(mst_space, mst_addr);
                ops.push_back({mst_space, mst_addr});
            end
            if (!rst && mst_req && mst_space && out_valid && !out_ready) viol++;
            if (!rst && out_valid && out_ready) rx.push_back(out_data);
        end
    end

    task automatic chk(string rq, logic ok, string what, longint act, longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic slv_write(logic [15:0] a, logic [15:0] d, logic sh = 1'b1);
        @(negedge clk);
        slv_wr = 1'b1; slv_short = sh; slv_addr = a; slv_wdata = d;
        @(negedge clk);
        slv_wr = 1'b0; slv_short = 1'b0;
    endtask

    task automatic program_all(int n);
        slv_write(WIN, 16'(n));
        p_n = (n > MAXE) ? MAXE : n;
        for (int e = 0; e < MAXE; e++) begin
            slv_write(WIN + 16'h0100 + 16'(2*e), p_cp[e]);
            slv_write(WIN + 16'h0200 + 16'(4*e), {8'h00, p_dp[e][23:16]});
            slv_write(WIN + 16'h0202 + 16'(4*e), p_dp[e][15:0]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        a_n = p_n;
        for (int e = 0; e < MAXE; e++) begin a_cp[e] = p_cp[e]; a_dp[e] = p_dp[e]; end
    endtask

    task automatic run_pass(int mid_start = 0);
        ops.delete(); rx.delete();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (mid_start != 0) begin
            repeat (mid_start) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_pass(string rq);
        logic [24:0] eops [$];
        logic [31:0] erx  [$];
        int bad;
        for (int e = 0; e < a_n; e++) begin
            int c;
            eops.push_back({1'b0, 8'h00, a_cp[e]});
            c = cnt_of.exists(a_cp[e]) ? int'(cnt_of[a_cp[e]]) : 0;
            for (int k = 0; k < c; k++) begin
                eops.push_back({1'b1, a_dp[e] + 24'(4*k)});
                erx.push_back({8'hC3, a_dp[e] + 24'(4*k)});
            end
        end
        chk(rq, ops.size() == eops.size(), "bus cycle count", ops.size(), eops.size());
        bad = -1;
        for (int i = 0; i < eops.size() && i < ops.size(); i++)
            if (bad < 0 && ops[i] !== eops[i]) bad = i;
        chk(rq, bad < 0, "bus cycle {space,addr}",
            bad < 0 ? 0 : ops[bad], bad < 0 ? 0 : eops[bad]);
        chk(rq, rx.size() == erx.size(), "output word count", rx.size(), erx.size());
        bad = -1;
        for (int i = 0; i < erx.size() && i < rx.size(); i++)
            if (bad < 0 && rx[i] !== erx[i]) bad = i;
        chk(rq, bad < 0, "output word", bad < 0 ? 0 : rx[bad], bad < 0 ? 0 : erx[bad]);
        chk("R10", done === 1'b1 && busy === 1'b0, "done/busy after pass", {done, busy}, 2'b10);
    endtask

    // R12: reset state
    task automatic t_reset();
        chk("R12", busy === 1'b0, "busy after reset", busy, 0);
        chk("R12", done === 1'b0, "done after reset", done, 0);
        chk("R12", out_valid === 1'b0, "out_valid after reset", out_valid, 0);
        chk("R12", mst_req === 1'b0, "mst_req after reset", mst_req, 0);
    endtask

    // R2 R5 R6 R7: three entries, data pointers with nonzero upper byte
    task automatic t_basic();
        p_cp[0] = 16'h0010; p_cp[1] = 16'h0020; p_cp[2] = 16'h0030;
        p_dp[0] = 24'h012000; p_dp[1] = 24'h340100; p_dp[2] = 24'hABCDE0;
        cnt_of[16'h0010] = 16'd2; cnt_of[16'h0020] = 16'd3; cnt_of[16'h0030] = 16'd4;
        program_all(3);
        do_reset();
        run_pass();
        expect_pass("R5/R6/R7 basic pass");
    endtask

    // R8: zero count in the middle entry
    task automatic t_zero();
        cnt_of[16'h0020] = 16'd0;
        run_pass();
        expect_pass("R8 zero count");
    endtask

    // R11: random back-pressure
    task automatic t_backpressure();
        cnt_of[16'h0020] = 16'd7;
        viol = 0; bp_mode = 1'b1;
        run_pass();
        bp_mode = 1'b0;
        expect_pass("R11 back-pressure");
        chk("R11", viol == 0, "data reads while output stalled", viol, 0);
    endtask

    // R10: done clears and busy rises on the next start
    task automatic t_done_clear();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R10", done === 1'b0 && busy === 1'b1, "done/busy after start", {done, busy}, 2'b01);
        for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // R3: edits wait for reset
    task automatic t_shadow();
        p_cp[0] = 16'h0040; p_cp[1] = 16'h0050;
        p_dp[0] = 24'h7F0000; p_dp[1] = 24'h000400;
        cnt_of[16'h0040] = 16'd1; cnt_of[16'h0050] = 16'd2;
        program_all(2);
        run_pass();
        expect_pass("R3 edits before reset ignored");
        do_reset();
        run_pass();
        expect_pass("R3 edits adopted at reset");
    endtask

    // R1: writes outside the window or not in short space
    task automatic t_window();
        slv_write(WIN, 16'd1, 1'b0);
        slv_write(16'hC000, 16'd1);
        slv_write(16'hC100, 16'h0010);
        slv_write(WIN + 16'h0100, 16'h0030, 1'b0);
        do_reset();
        run_pass();
        expect_pass("R1 foreign writes ignored");
    endtask

    // R4: entry count clamp
    task automatic t_clamp();
        for (int e = 0; e < MAXE; e++) begin
            p_cp[e] = 16'h0100 + 16'(e*2);
            p_dp[e] = 24'h200000 + 24'(e * 24'h1000);
            cnt_of[p_cp[e]] = 16'(e % 3);
        end
        program_all(100);
        do_reset();
        run_pass();
        expect_pass("R4 clamp to maximum");
    endtask

    // R9: start while busy ignored
    task automatic t_start_busy();
        run_pass(4);
        expect_pass("R9 start while busy");
    endtask

    // R9: empty list
    task automatic t_empty();
        program_all(0);
        do_reset();
        run_pass();
        chk("R9", ops.size() == 0, "bus cycles with zero entries", ops.size(), 0);
        chk("R9", done === 1'b1, "done with zero entries", done, 1);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        for (int e = 0; e < MAXE; e++) begin p_cp[e] = '0; p_dp[e] = '0; end
        p_n = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_zero();
        t_backpressure();
        t_done_clear();
        t_shadow();
        t_window();
        t_clamp();
        t_start_busy();
        t_empty();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish actual=hung expected=finished");
        summary();
        $finish;
    end

endmodule